// File: doc/BRIEF.md
# SPI Slave Burst Bridge to a Parallel Memory Port

This block is an SPI slave that gives an external SPI master read and write access to a passive parallel device, such as a small RAM or a display controller. It runs entirely on the system clock. The serial clock, the active-low select and the serial input are oversampled through two-flop synchronizers, and the serial output comes from a transmit shift register.

Each transfer opens with an address word, which is loaded onto the address bus and immediately followed by a read. Every word after that is exchanged full-duplex. The master receives the prefetched read data while it sends write data. When a data word is complete, the block writes it to the current address, increments the address and prefetches the next location.

The parallel side has no back-pressure. The read and write strobes are single-cycle commands, and the device must return read data combinationally from the address while the read strobe is high. The serial side is paced only by the master.

Top module: `spi_mem_bridge`

## Requirements
- R1: While reset is asserted and right after it is released, `mem_rd` and `mem_we` are low, `sdo` is 0 and `mem_addr` is 0.
- R2: The first `ADDR_W` bits after `ss_n` falls are taken MSB first as the address and driven on `mem_addr`. One single-cycle `mem_rd` pulse follows at that address.
- R3: `sdo` is 0 for every bit of the address word.
- R4: The `mem_rdata` value captured during a `mem_rd` pulse is returned MSB first on `sdo` during the next data word. With CPHA=0 its MSB is present before the word's first SCK edge. With CPHA=1 it is present from the first SCK edge.
- R5: When all `DATA_W` bits of a data word have been sampled, the word appears on `mem_wdata` and `mem_we` pulses for one cycle at the current `mem_addr`.
- R6: In the cycle after a `mem_we` pulse, `mem_addr` equals the previous address plus one, and `mem_rd` pulses for one cycle.
- R7: All four serial modes work. With CPOL=0, SCK idles low; with CPOL=1, it idles high. With CPHA=0, `sdi` is sampled on the first SCK edge of each bit; with CPHA=1, it is sampled on the second.
- R8: If `ss_n` rises partway through a word, that word is discarded. No `mem_we` is issued for it, `mem_addr` is not incremented, and the next transfer starts again with an address word.
- R9: `sdo` is 0 while the slave is deselected.
- R10: `mem_rd` and `mem_we` are never high in the same cycle, and neither stays high for two cycles in a row.
- R11: The address increments modulo 2^`ADDR_W`, so a burst that starts at the top address continues at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | SCK idle level (1 = idle high) |
| cpha | input | 1 | 0: sample on the first SCK edge of a bit; 1: sample on the second |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master |
| mem_addr | output | ADDR_W | Address to the parallel device |
| mem_rd | output | 1 | Single-cycle read strobe |
| mem_rdata | input | DATA_W | Read data, valid while `mem_rd` is high |
| mem_wdata | output | DATA_W | Write data |
| mem_we | output | 1 | Single-cycle write strobe |

## Verification
The assertions rely on four assumptions about the inputs:
- `cpol` and `cpha` change only while `ss_n` is high.
- `ss_n` stays high for at least four system clocks between transfers.
- The SCK half-period is at least four system clocks, so a prefetched word reaches the transmit register before the master samples its MSB.
- The parallel device answers a read within the strobe cycle.

The bench's master task uses a four-clock half-period and leaves idle gaps of eight clocks or more around each select. It changes the mode pins only while deselected, and it models the device as a combinational array, so every stimulus stays inside those assumptions.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_bridge_sync.sv
module spi_bridge_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i] <= RST_VAL[i];
        q[i]    <= RST_VAL[i];
      end else begin
        meta[i] <= d[i];
        q[i]    <= meta[i];
      end
    end
  end

endmodule

// File: rtl/spi_bridge_clkedge.sv
module spi_bridge_clkedge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cpol,
  input  logic cpha,
  output logic sample_p,
  output logic shift_p
);

  logic sck_q;
  logic toggled;
  logic leading;
  logic trailing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  // Leading edge leaves the idle level, trailing edge returns to it.
  assign toggled  = sck_s ^ sck_q;
  assign leading  = toggled & (sck_q == cpol);
  assign trailing = toggled & (sck_s == cpol);

  assign sample_p = cpha ? trailing : leading;
  assign shift_p  = cpha ? leading  : trailing;

endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge
  import spi_bridge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              sdi,
  output logic              sdo,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we
);

  localparam int MAXW  = max_int(ADDR_W, DATA_W);
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  logic sck_s, ss_s, sdi_s;
  logic ss_q;
  logic sample_p, shift_p;

  phase_e            phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  last_bit;
  logic [MAXW-1:0]   rx_sr;
  logic [MAXW-1:0]   rx_next;
  logic [DATA_W-1:0] tx_sr;
  logic              start;
  logic              active;

  spi_bridge_sync #(.WIDTH(3), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sck, ss_n, sdi}),
    .q     ({sck_s, ss_s, sdi_s})
  );

  spi_bridge_clkedge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (sck_s),
    .cpol     (cpol),
    .cpha     (cpha),
    .sample_p (sample_p),
    .shift_p  (shift_p)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_q <= 1'b1;
    else        ss_q <= ss_s;
  end

  assign start    = ss_q & ~ss_s;
  assign active   = (phase != PH_IDLE);
  assign last_bit = (phase == PH_ADDR) ? ADDR_LAST : DATA_LAST;
  assign rx_next  = {rx_sr[MAXW-2:0], sdi_s};
  assign sdo      = active & tx_sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_rd    <= 1'b0;
      mem_we    <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      mem_we <= 1'b0;

      // Write completes, then step the address and prefetch.
      if (mem_we) begin
        mem_addr <= mem_addr + 1'b1;
        mem_rd   <= 1'b1;
      end

      // Prefetched data loads the transmit register.
      if (mem_rd) tx_sr <= mem_rdata;

      if (ss_s) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
      end else if (start) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        rx_sr   <= '0;
        tx_sr   <= '0;
      end else if (active) begin
        if (shift_p && bit_cnt != '0)
          tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        if (sample_p) begin
          rx_sr <= rx_next;
          if (bit_cnt == last_bit) begin
            bit_cnt <= '0;
            if (phase == PH_ADDR) begin
              mem_addr <= rx_next[ADDR_W-1:0];
              mem_rd   <= 1'b1;
              phase    <= PH_DATA;
            end else begin
              mem_wdata <= rx_next[DATA_W-1:0];
              mem_we    <= 1'b1;
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_mem_bridge_chk.sv
module spi_mem_bridge_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ss_n,
  input logic              sdo,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we
);

  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  assert_we_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_rd_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R6 and R11: address step (modulo) with prefetch right after a write.
  assert_inc_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_rd && mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  assert_wdata_with_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_wdata) |-> mem_we);

  assert_sdo_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n) && $past(ss_n, 2) && $past(ss_n, 3)) |-> !sdo);

endmodule

bind spi_mem_bridge spi_mem_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_spi_mem_bridge.sv
module tb_spi_mem_bridge;

  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpol = 1'b0, cpha = 1'b0;
  logic       sck = 1'b0, ss_n = 1'b1, sdi = 1'b0;
  logic       sdo;
  logic [7:0] mem_addr, mem_rdata, mem_wdata;
  logic       mem_rd, mem_we;

  int tests = 0, fails = 0;
  int rd_cnt = 0, we_cnt = 0;
  bit done = 1'b0;

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];

  always #5 clk = ~clk;

  spi_mem_bridge #(.ADDR_W(8), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .sck(sck),
    .ss_n(ss_n), .sdi(sdi), .sdo(sdo), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  // Passive device model: combinational read, write on the strobe.
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        we_cnt <= we_cnt + 1;
      end
      if (mem_rd) rd_cnt <= rd_cnt + 1;
    end
  end

  // {cpol, cpha, address, write word 0, write word 1}
  localparam logic [25:0] VEC [4] = '{
    {1'b0, 1'b0, 8'h10, 8'hA1, 8'hB2},
    {1'b0, 1'b1, 8'h40, 8'h3C, 8'hC3},
    {1'b1, 1'b0, 8'h7F, 8'h81, 8'h18},
    {1'b1, 1'b1, 8'hC3, 8'hE7, 8'h0F}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic select_on(input logic pol, input logic pha);
    cpol = pol; cpha = pha; sck = pol;
    tick(8);
    ss_n = 1'b0;
    tick(H);
  endtask

  task automatic select_off();
    tick(H);
    ss_n = 1'b1;
    tick(10);
  endtask

  // Sends bits val[7] downward, nbits of them; returns what the master sampled.
  task automatic word(input int nbits, input logic [7:0] val, output logic [7:0] got);
    got = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!cpha) begin
        sdi = val[i];
        tick(H);
        got = {got[6:0], sdo};
        sck = ~cpol;
        tick(H);
        sck = cpol;
      end else begin
        sck = ~cpol;
        sdi = val[i];
        tick(H);
        got = {got[6:0], sdo};
        sck = cpol;
        tick(H);
      end
    end
  endtask

  task automatic burst(input logic pol, input logic pha, input logic [7:0] a,
                       input logic [7:0] w0, input logic [7:0] w1, input string tag);
    logic [7:0] g_a, g0, g1;
    logic [7:0] e0, e1;
    int rd0, we0;
    e0 = ref_mem[a];
    e1 = ref_mem[8'(a + 8'd1)];
    rd0 = rd_cnt; we0 = we_cnt;
    select_on(pol, pha);
    word(8, a, g_a);
    word(8, w0, g0);
    word(8, w1, g1);
    select_off();
    ref_mem[a] = w0;
    ref_mem[8'(a + 8'd1)] = w1;
    chk({"R3 address-phase sdo zero ", tag}, {24'd0, g_a}, 32'd0);
    chk({"R4 R7 readback word0 ", tag}, {24'd0, g0}, {24'd0, e0});
    chk({"R4 R7 readback word1 ", tag}, {24'd0, g1}, {24'd0, e1});
    chk({"R5 R7 written word0 ", tag}, {24'd0, mem[a]}, {24'd0, w0});
    chk({"R5 R6 written word1 ", tag}, {24'd0, mem[8'(a + 8'd1)]}, {24'd0, w1});
    chk({"R5 write count ", tag}, 32'(we_cnt - we0), 32'd2);
    chk({"R2 R6 read count ", tag}, 32'(rd_cnt - rd0), 32'd3);
    chk({"R6 final address ", tag}, {24'd0, mem_addr}, {24'd0, 8'(a + 8'd2)});
    chk({"R9 sdo deselected ", tag}, {31'd0, sdo}, 32'd0);
  endtask

  initial begin
    logic [7:0] g, g2;
    int we0;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i) ^ 8'h5A;
    tick(5);
    chk("R1 rd low in reset", {31'd0, mem_rd}, 32'd0);
    chk("R1 we low in reset", {31'd0, mem_we}, 32'd0);
    rst_n = 1'b1;
    tick(3);
    chk("R1 addr zero", {24'd0, mem_addr}, 32'd0);
    chk("R1 sdo zero", {31'd0, sdo}, 32'd0);
    chk("R1 no strobes", {30'd0, mem_rd, mem_we}, 32'd0);

    for (int v = 0; v < 4; v++)
      burst(VEC[v][25], VEC[v][24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0],
            $sformatf("vec%0d", v));

    // R11: burst from the top address wraps to zero.
    burst(1'b1, 1'b1, 8'hFF, 8'h66, 8'h99, "wrap R11");
    chk("R11 wrapped address", {24'd0, mem_addr}, 32'd1);

    // R8: select released partway through a data word.
    we0 = we_cnt;
    select_on(1'b0, 1'b0);
    word(8, 8'h20, g);
    word(3, 8'hFF, g);
    select_off();
    chk("R8 no write on partial word", 32'(we_cnt - we0), 32'd0);
    chk("R8 memory unchanged", {24'd0, mem[8'h20]}, {24'd0, ref_mem[8'h20]});
    chk("R8 address not advanced", {24'd0, mem_addr}, 32'h20);

    // R8: next transfer restarts with an address word.
    select_on(1'b0, 1'b1);
    word(8, 8'h21, g);
    word(8, 8'h77, g2);
    select_off();
    chk("R8 restart address phase", {24'd0, g}, 32'd0);
    chk("R8 restart readback", {24'd0, g2}, {24'd0, ref_mem[8'h21]});
    ref_mem[8'h21] = 8'h77;
    chk("R8 restart write", {24'd0, mem[8'h21]}, 32'h77);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule